// File: doc/BRIEF.md
# Compressed Instruction Decoder

This block sits behind the fetch unit of a 64-bit integer core. Each fetch word enters through a valid/ready handshake. The block looks at the two lowest bits to decide whether the word is a 16-bit compressed instruction or a full 32-bit one. Compressed words are broken down into an operation code, destination and source register numbers, an immediate that has been reassembled and extended, an instruction length, and an illegal flag. A 32-bit word is only marked with length 4 and handed on to a wide decoder further down the pipe.

The decode result is held in a single output register with its own valid/ready pair. A result stays on the outputs until the consumer takes it. A new word is accepted only on a cycle where the input is valid and `in_ready` is high.

Top module: `cinsn_decoder`

## Requirements
- R1: If `in_word[1:0]` is 2'b11, the output is op 21 (wide), length 4, illegal 0, and all register and immediate fields 0. Any other value in those bits gives length 2. Bits [31:16] never affect how a compressed word decodes.
- R2: These words give illegal=1 with op 0 and all register and immediate fields 0: the all-zero halfword; quadrant 0 with funct3 (bits [15:13]) 001, 100 or 101; quadrant 1 with funct3 100 or 101; quadrant 2 with funct3 010, 101 or 110; quadrant 2 with funct3 100, bit 12 = 0 and bits [6:2] = 0.
- R3: A 3-bit register field (bits [4:2] or bits [9:7]) names register 8 plus the field value.
- R4: Quadrant 0, funct3 000 (nonzero word) is op 1. It has rd = 8+[4:2], rs1 = 2, and a zero-extended immediate where imm[9:6]=[10:7], imm[5:4]=[12:11], imm[3]=[5], imm[2]=[6].
- R5: Quadrant 0 funct3 010/011/110/111 give op 2 (word load), 3 (doubleword load), 4 (word store) and 5 (doubleword store). Loads have rd = 8+[4:2] and rs1 = 8+[9:7]. Stores have rs1 = 8+[9:7] and rs2 = 8+[4:2]. The word forms zero-extend imm[6]=[5], imm[5:3]=[12:10], imm[2]=[6]. The doubleword forms zero-extend imm[7:6]=[6:5], imm[5:3]=[12:10].
- R6: Quadrant 1 funct3 000, 001 and 010 give op 6 (add immediate) and op 7 (add immediate word), both with rd = rs1 = [11:7], and op 8 (load immediate) with rd = [11:7] and rs1 = 0. All three take a sign-extended 6-bit immediate {[12],[6:2]}.
- R7: Quadrant 1 funct3 011 depends on [11:7]. With [11:7] = 2 it is op 9, rd = rs1 = 2, and a sign-extended immediate built as imm[9]=[12], imm[8:7]=[4:3], imm[6]=[5], imm[5]=[2], imm[4]=[6]. With any other value it is op 10, rd = [11:7], and imm = sign-extended {[12],[6:2],12'b0}.
- R8: Quadrant 1 funct3 110 and 111 give op 11 (branch if zero) and op 12 (branch if nonzero), with rs1 = 8+[9:7] and rs2 = 0. The offset is sign-extended with off[8]=[12], off[7:6]=[6:5], off[5]=[2], off[4:3]=[11:10], off[2:1]=[4:3].
- R9: In quadrant 2, funct3 000 is op 13 with rd = rs1 = [11:7] and a zero-extended immediate {[12],[6:2]}. Funct3 001 and 011 give op 14 and op 15, with rd = [11:7], rs1 = 2, and zero-extended imm[8:6]=[4:2], imm[5]=[12], imm[4:3]=[6:5]. Funct3 111 is op 20 with rs1 = 2, rs2 = [6:2], and zero-extended imm[8:6]=[9:7], imm[5:3]=[12:10].
- R10: Quadrant 2 funct3 100 decodes as follows:
  - bit 12 = 0 with [6:2] ≠ 0: op 16, rd = [11:7], rs1 = 0, rs2 = [6:2];
  - bit 12 = 1 with [6:2] = 0 and [11:7] = 0: op 17 with all fields 0;
  - bit 12 = 1 with [6:2] = 0 and [11:7] ≠ 0: op 18, rd = 1, rs1 = [11:7], imm 0;
  - bit 12 = 1 with [6:2] ≠ 0: op 19, rd = rs1 = [11:7], rs2 = [6:2].
- R11: `in_ready` equals `!out_valid || out_ready` once reset has been released. A word accepted on a valid-and-ready edge shows up decoded on the outputs right after that edge. If the output is taken and no word is accepted, `out_valid` drops.
- R12: While `out_valid` is high and `out_ready` is low, every output holds its value.
- R13: While `rst_n` is low, `out_valid` and `in_ready` are 0. A few cycles after release, `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Fetch word present |
| in_ready | output | 1 | Decoder can take a word |
| in_word | input | 32 | Fetch word, instruction in the low bits |
| out_valid | output | 1 | Decode result present |
| out_ready | input | 1 | Consumer takes the result |
| out_op | output | 5 | Operation code |
| out_rd | output | 5 | Destination register |
| out_rs1 | output | 5 | First source register |
| out_rs2 | output | 5 | Second source register |
| out_imm | output | XLEN | Reassembled, extended immediate |
| out_len | output | 3 | Instruction length in bytes (2 or 4) |
| out_illegal | output | 1 | Compressed encoding not recognised |

## Verification
The bench uses the default XLEN of 64 and a two-stage reset synchronizer. With 64-bit immediates, a wrong sign extension above bit 31 is caught, not only one in the low bits. Directed words cover every quadrant/funct3 pair, all-ones and all-zero immediate patterns, and the rd = 2 and rs2 = 0 splits. A long run of pseudo-random words with random upper halves and irregular valid/ready traffic is compared against a behavioural model on every cycle, which exercises stalls and back-to-back acceptance.

// File: rtl/cdec_pkg.sv
`timescale 1ns/1ps
package cdec_pkg;

  localparam int OP_W  = 5;
  localparam int REG_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ILLEGAL = 5'd0,
    OP_SP_ADDR = 5'd1,
    OP_LDW     = 5'd2,
    OP_LDD     = 5'd3,
    OP_STW     = 5'd4,
    OP_STD     = 5'd5,
    OP_ADDI    = 5'd6,
    OP_ADDIW   = 5'd7,
    OP_LDI     = 5'd8,
    OP_SP_ADJ  = 5'd9,
    OP_LDUP    = 5'd10,
    OP_BRZ     = 5'd11,
    OP_BRNZ    = 5'd12,
    OP_SHLI    = 5'd13,
    OP_FPLD_SP = 5'd14,
    OP_LDD_SP  = 5'd15,
    OP_MOVE    = 5'd16,
    OP_BREAK   = 5'd17,
    OP_JLR     = 5'd18,
    OP_ADDR    = 5'd19,
    OP_STD_SP  = 5'd20,
    OP_WIDE    = 5'd21
  } cop_e;

  typedef struct packed {
    cop_e             op;
    logic [REG_W-1:0] rd;
    logic [REG_W-1:0] rs1;
    logic [REG_W-1:0] rs2;
    logic             wide;
    logic             ill;
  } cdec_fields_t;

  localparam logic [REG_W-1:0] REG_ZERO = 5'd0;
  localparam logic [REG_W-1:0] REG_LINK = 5'd1;
  localparam logic [REG_W-1:0] REG_SP   = 5'd2;

  // 3-bit register field -> registers 8..15
  function automatic logic [REG_W-1:0] prime_reg(input logic [2:0] f);
    return {2'b01, f};
  endfunction

endpackage

// File: rtl/cdec_sext.sv
`timescale 1ns/1ps
module cdec_sext #(
  parameter int IW   = 6,
  parameter int XLEN = 64
) (
  input  logic [IW-1:0]   v,
  output logic [XLEN-1:0] o
);
  localparam int PAD = XLEN - IW;
  assign o = {{PAD{v[IW-1]}}, v};
endmodule

// File: rtl/cdec_imm.sv
`timescale 1ns/1ps
module cdec_imm #(
  parameter int XLEN = 64
) (
  input  logic [12:2]     hb,
  output logic [XLEN-1:0] imm_spaddr,
  output logic [XLEN-1:0] imm_word,
  output logic [XLEN-1:0] imm_dword,
  output logic [XLEN-1:0] imm_s6,
  output logic [XLEN-1:0] imm_u6,
  output logic [XLEN-1:0] imm_adj,
  output logic [XLEN-1:0] imm_upper,
  output logic [XLEN-1:0] imm_br,
  output logic [XLEN-1:0] imm_spld,
  output logic [XLEN-1:0] imm_spst
);
  localparam int SW_S6  = 6;
  localparam int SW_ADJ = 10;
  localparam int SW_UP  = 18;
  localparam int SW_BR  = 9;

  logic [SW_S6-1:0]  raw_s6;
  logic [SW_ADJ-1:0] raw_adj;
  logic [SW_UP-1:0]  raw_up;
  logic [SW_BR-1:0]  raw_br;

  // scrambled positions gathered back into place
  assign raw_s6  = {hb[12], hb[6:2]};
  assign raw_adj = {hb[12], hb[4:3], hb[5], hb[2], hb[6], 4'b0000};
  assign raw_up  = {hb[12], hb[6:2], 12'h000};
  assign raw_br  = {hb[12], hb[6:5], hb[2], hb[11:10], hb[4:3], 1'b0};

  cdec_sext #(.IW(SW_S6),  .XLEN(XLEN)) u_sx_s6  (.v(raw_s6),  .o(imm_s6));
  cdec_sext #(.IW(SW_ADJ), .XLEN(XLEN)) u_sx_adj (.v(raw_adj), .o(imm_adj));
  cdec_sext #(.IW(SW_UP),  .XLEN(XLEN)) u_sx_up  (.v(raw_up),  .o(imm_upper));
  cdec_sext #(.IW(SW_BR),  .XLEN(XLEN)) u_sx_br  (.v(raw_br),  .o(imm_br));

  assign imm_spaddr = {{(XLEN-10){1'b0}}, hb[10:7], hb[12:11], hb[5], hb[6], 2'b00};
  assign imm_word   = {{(XLEN-7){1'b0}},  hb[5], hb[12:10], hb[6], 2'b00};
  assign imm_dword  = {{(XLEN-8){1'b0}},  hb[6:5], hb[12:10], 3'b000};
  assign imm_u6     = {{(XLEN-6){1'b0}},  raw_s6};
  assign imm_spld   = {{(XLEN-9){1'b0}},  hb[4:2], hb[12], hb[6:5], 3'b000};
  assign imm_spst   = {{(XLEN-9){1'b0}},  hb[9:7], hb[12:10], 3'b000};
endmodule

// File: rtl/cdec_core.sv
`timescale 1ns/1ps
module cdec_core
  import cdec_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [15:0]     hw,
  output cdec_fields_t    fld,
  output logic [XLEN-1:0] imm
);
  logic [1:0]       quad;
  logic [2:0]       f3;
  logic [REG_W-1:0] r_full;
  logic [REG_W-1:0] r2_full;
  logic [REG_W-1:0] rp_hi;
  logic [REG_W-1:0] rp_lo;
  logic             bit12;

  logic [XLEN-1:0] i_spaddr, i_word, i_dword, i_s6, i_u6;
  logic [XLEN-1:0] i_adj, i_upper, i_br, i_spld, i_spst;

  assign quad    = hw[1:0];
  assign f3      = hw[15:13];
  assign r_full  = hw[11:7];
  assign r2_full = hw[6:2];
  assign rp_hi   = prime_reg(hw[9:7]);
  assign rp_lo   = prime_reg(hw[4:2]);
  assign bit12   = hw[12];

  cdec_imm #(.XLEN(XLEN)) u_imm (
    .hb        (hw[12:2]),
    .imm_spaddr(i_spaddr),
    .imm_word  (i_word),
    .imm_dword (i_dword),
    .imm_s6    (i_s6),
    .imm_u6    (i_u6),
    .imm_adj   (i_adj),
    .imm_upper (i_upper),
    .imm_br    (i_br),
    .imm_spld  (i_spld),
    .imm_spst  (i_spst)
  );

  always_comb begin
    fld.op   = OP_ILLEGAL;
    fld.rd   = REG_ZERO;
    fld.rs1  = REG_ZERO;
    fld.rs2  = REG_ZERO;
    fld.wide = 1'b0;
    fld.ill  = 1'b0;
    imm      = '0;
    if (quad == 2'b11) begin
      fld.op   = OP_WIDE;
      fld.wide = 1'b1;
    end else begin
      unique case ({quad, f3})
        5'b00_000: begin
          if (hw == 16'h0000) begin
            fld.ill = 1'b1;
          end else begin
            fld.op  = OP_SP_ADDR;
            fld.rd  = rp_lo;
            fld.rs1 = REG_SP;
            imm     = i_spaddr;
          end
        end
        5'b00_010: begin
          fld.op = OP_LDW; fld.rd = rp_lo; fld.rs1 = rp_hi; imm = i_word;
        end
        5'b00_011: begin
          fld.op = OP_LDD; fld.rd = rp_lo; fld.rs1 = rp_hi; imm = i_dword;
        end
        5'b00_110: begin
          fld.op = OP_STW; fld.rs1 = rp_hi; fld.rs2 = rp_lo; imm = i_word;
        end
        5'b00_111: begin
          fld.op = OP_STD; fld.rs1 = rp_hi; fld.rs2 = rp_lo; imm = i_dword;
        end
        5'b01_000: begin
          fld.op = OP_ADDI; fld.rd = r_full; fld.rs1 = r_full; imm = i_s6;
        end
        5'b01_001: begin
          fld.op = OP_ADDIW; fld.rd = r_full; fld.rs1 = r_full; imm = i_s6;
        end
        5'b01_010: begin
          fld.op = OP_LDI; fld.rd = r_full; imm = i_s6;
        end
        5'b01_011: begin
          if (r_full == REG_SP) begin
            fld.op = OP_SP_ADJ; fld.rd = REG_SP; fld.rs1 = REG_SP; imm = i_adj;
          end else begin
            fld.op = OP_LDUP; fld.rd = r_full; imm = i_upper;
          end
        end
        5'b01_110: begin
          fld.op = OP_BRZ; fld.rs1 = rp_hi; imm = i_br;
        end
        5'b01_111: begin
          fld.op = OP_BRNZ; fld.rs1 = rp_hi; imm = i_br;
        end
        5'b10_000: begin
          fld.op = OP_SHLI; fld.rd = r_full; fld.rs1 = r_full; imm = i_u6;
        end
        5'b10_001: begin
          fld.op = OP_FPLD_SP; fld.rd = r_full; fld.rs1 = REG_SP; imm = i_spld;
        end
        5'b10_011: begin
          fld.op = OP_LDD_SP; fld.rd = r_full; fld.rs1 = REG_SP; imm = i_spld;
        end
        5'b10_111: begin
          fld.op = OP_STD_SP; fld.rs1 = REG_SP; fld.rs2 = r2_full; imm = i_spst;
        end
        5'b10_100: begin
          if (!bit12) begin
            if (r2_full != REG_ZERO) begin
              fld.op = OP_MOVE; fld.rd = r_full; fld.rs2 = r2_full;
            end else begin
              fld.ill = 1'b1;
            end
          end else if (r2_full == REG_ZERO) begin
            if (r_full == REG_ZERO) begin
              fld.op = OP_BREAK;
            end else begin
              fld.op = OP_JLR; fld.rd = REG_LINK; fld.rs1 = r_full;
            end
          end else begin
            fld.op = OP_ADDR; fld.rd = r_full; fld.rs1 = r_full; fld.rs2 = r2_full;
          end
        end
        default: fld.ill = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/cdec_rsync.sv
`timescale 1ns/1ps
module cdec_rsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/cdec_stage.sv
`timescale 1ns/1ps
module cdec_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         srst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] d,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] q
);
  logic         vld_q, vld_d;
  logic [W-1:0] dat_q;
  logic         take;

  assign in_ready = srst_n && (!vld_q || out_ready);
  assign take     = in_valid && in_ready;

  always_comb begin
    vld_d = vld_q;
    if (take)           vld_d = 1'b1;
    else if (out_ready) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (take) dat_q <= d;
    end
  end

  assign out_valid = vld_q;
  assign q         = dat_q;
endmodule

// File: rtl/cinsn_decoder.sv
`timescale 1ns/1ps
module cinsn_decoder
  import cdec_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int RS_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [31:0]     in_word,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [4:0]      out_op,
  output logic [4:0]      out_rd,
  output logic [4:0]      out_rs1,
  output logic [4:0]      out_rs2,
  output logic [XLEN-1:0] out_imm,
  output logic [2:0]      out_len,
  output logic            out_illegal
);
  localparam int FW = $bits(cdec_fields_t);
  localparam int PW = FW + XLEN;

  logic            srst_n;
  cdec_fields_t    dec_f, hold_f;
  logic [XLEN-1:0] dec_imm, hold_imm;
  logic [PW-1:0]   pack_d, pack_q;
  logic            unused_upper;

  assign unused_upper = ^in_word[31:16];

  cdec_rsync #(.STAGES(RS_STAGES)) u_rs (
    .clk   (clk),
    .rst_n (rst_n),
    .srst_n(srst_n)
  );

  cdec_core #(.XLEN(XLEN)) u_core (
    .hw (in_word[15:0]),
    .fld(dec_f),
    .imm(dec_imm)
  );

  assign pack_d = {dec_f, dec_imm};

  cdec_stage #(.W(PW)) u_stage (
    .clk      (clk),
    .srst_n   (srst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .d        (pack_d),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .q        (pack_q)
  );

  assign {hold_f, hold_imm} = pack_q;

  assign out_op      = hold_f.op;
  assign out_rd      = hold_f.rd;
  assign out_rs1     = hold_f.rs1;
  assign out_rs2     = hold_f.rs2;
  assign out_imm     = hold_imm;
  assign out_len     = hold_f.wide ? 3'd4 : 3'd2;
  assign out_illegal = hold_f.ill;
endmodule

// File: rtl/cdec_chk.sv
`timescale 1ns/1ps
module cdec_chk
  import cdec_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [4:0]      out_op,
  input logic [4:0]      out_rd,
  input logic [4:0]      out_rs1,
  input logic [4:0]      out_rs2,
  input logic [XLEN-1:0] out_imm,
  input logic [2:0]      out_len,
  input logic            out_illegal
);
  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R11

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_op) && $stable(out_rd)
      && $stable(out_rs1) && $stable(out_rs2) && $stable(out_imm)
      && $stable(out_len) && $stable(out_illegal)); // R12

  AST_LEN_MATCHES_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_len == 3'd4) == (out_op == OP_WIDE))); // R1

  AST_ILLEGAL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> out_op == OP_ILLEGAL && out_rd == 5'd0
      && out_rs1 == 5'd0 && out_rs2 == 5'd0 && out_imm == '0); // R2

  AST_PRIME_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_op == OP_LDW || out_op == OP_LDD || out_op == OP_STW
      || out_op == OP_STD) |-> out_rs1[4:3] == 2'b01); // R3

  AST_BRANCH_VS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_op == OP_BRZ || out_op == OP_BRNZ)
      |-> out_rs2 == 5'd0 && out_rs1[4:3] == 2'b01 && out_imm[0] == 1'b0); // R8

  AST_SP_RELATIVE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_op == OP_FPLD_SP || out_op == OP_LDD_SP
      || out_op == OP_STD_SP) |-> out_rs1 == 5'd2 && out_imm[2:0] == 3'b000); // R9

  AST_SPADDR_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_op == OP_SP_ADDR |-> out_rs1 == 5'd2 && out_imm[XLEN-1:10] == '0); // R4
endmodule

bind cinsn_decoder cdec_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_op     (out_op),
  .out_rd     (out_rd),
  .out_rs1    (out_rs1),
  .out_rs2    (out_rs2),
  .out_imm    (out_imm),
  .out_len    (out_len),
  .out_illegal(out_illegal)
);

// File: tb/sim_cinsn_decoder.sv
`timescale 1ns/1ps
module sim_cinsn_decoder;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid, in_ready, out_valid, out_ready;
  logic [31:0]     in_word;
  logic [4:0]      out_op, out_rd, out_rs1, out_rs2;
  logic [XLEN-1:0] out_imm;
  logic [2:0]      out_len;
  logic            out_illegal;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  cinsn_decoder #(.XLEN(XLEN)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_op(out_op), .out_rd(out_rd), .out_rs1(out_rs1), .out_rs2(out_rs2),
    .out_imm(out_imm), .out_len(out_len), .out_illegal(out_illegal)
  );

  typedef struct {
    int          op;
    int          rd;
    int          rs1;
    int          rs2;
    logic [63:0] imm;
    int          len;
    int          ill;
  } exp_t;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int fb(input logic [15:0] h, input int hi, input int lo);
    return int'((h >> lo) & ((32'd1 << (hi - lo + 1)) - 1));
  endfunction

  function automatic logic [63:0] sx(input int v, input int n);
    logic [63:0] r;
    r = 64'(v);
    if (((v >> (n - 1)) & 1) == 1) r = r | (~64'd0 << n);
    return r;
  endfunction

  function automatic exp_t model(input logic [31:0] w);
    exp_t e;
    logic [15:0] h;
    int q, f3, ra, rb, pa, pb, s12;
    e = '{op: 0, rd: 0, rs1: 0, rs2: 0, imm: 64'd0, len: 2, ill: 0};
    if (w[1:0] == 2'b11) begin
      e.op = 21; e.len = 4;
      return e;
    end
    h = w[15:0];
    q = fb(h, 1, 0); f3 = fb(h, 15, 13);
    ra = fb(h, 11, 7); rb = fb(h, 6, 2);
    pa = 8 + fb(h, 9, 7); pb = 8 + fb(h, 4, 2);
    s12 = fb(h, 12, 12);
    case (q * 8 + f3)
      0: if (h == 16'd0) e.ill = 1;
         else begin
           e.op = 1; e.rd = pb; e.rs1 = 2;
           e.imm = 64'(fb(h,12,11)*16 + fb(h,10,7)*64 + fb(h,6,6)*4 + fb(h,5,5)*8);
         end
      2, 3, 6, 7: begin
        if (f3 == 2 || f3 == 6) e.imm = 64'(fb(h,12,10)*8 + fb(h,6,6)*4 + fb(h,5,5)*64);
        else                    e.imm = 64'(fb(h,12,10)*8 + fb(h,6,5)*64);
        e.rs1 = pa;
        if (f3 < 4) begin e.rd = pb; e.op = (f3 == 2) ? 2 : 3; end
        else begin e.rs2 = pb; e.op = (f3 == 6) ? 4 : 5; end
      end
      8, 9: begin
        e.op = (f3 == 0) ? 6 : 7; e.rd = ra; e.rs1 = ra; e.imm = sx(s12*32 + rb, 6);
      end
      10: begin e.op = 8; e.rd = ra; e.imm = sx(s12*32 + rb, 6); end
      11: if (ra == 2) begin
            e.op = 9; e.rd = 2; e.rs1 = 2;
            e.imm = sx(s12*512 + fb(h,4,3)*128 + fb(h,5,5)*64 + fb(h,2,2)*32 + fb(h,6,6)*16, 10);
          end else begin
            e.op = 10; e.rd = ra; e.imm = sx(s12*(1 << 17) + rb*(1 << 12), 18);
          end
      14, 15: begin
        e.op = (f3 == 6) ? 11 : 12; e.rs1 = pa;
        e.imm = sx(s12*256 + fb(h,11,10)*8 + fb(h,6,5)*64 + fb(h,4,3)*2 + fb(h,2,2)*32, 9);
      end
      16: begin e.op = 13; e.rd = ra; e.rs1 = ra; e.imm = 64'(s12*32 + rb); end
      17, 19: begin
        e.op = (f3 == 1) ? 14 : 15; e.rd = ra; e.rs1 = 2;
        e.imm = 64'(s12*32 + fb(h,6,5)*8 + fb(h,4,2)*64);
      end
      23: begin
        e.op = 20; e.rs1 = 2; e.rs2 = rb; e.imm = 64'(fb(h,12,10)*8 + fb(h,9,7)*64);
      end
      20: if (s12 == 0) begin
            if (rb != 0) begin e.op = 16; e.rd = ra; e.rs2 = rb; end
            else e.ill = 1;
          end else if (rb == 0) begin
            if (ra == 0) e.op = 17;
            else begin e.op = 18; e.rd = 1; e.rs1 = ra; end
          end else begin
            e.op = 19; e.rd = ra; e.rs1 = ra; e.rs2 = rb;
          end
      default: e.ill = 1;
    endcase
    return e;
  endfunction

  function automatic string tag_of(input exp_t e);
    if (e.len == 4) return "R1";
    if (e.ill != 0) return "R2";
    case (e.op)
      1: return "R4";
      2, 3, 4, 5: return "R5";
      6, 7, 8: return "R6";
      9, 10: return "R7";
      11, 12: return "R8";
      13, 14, 15, 20: return "R9";
      default: return "R10";
    endcase
  endfunction

  logic [31:0] words[$];
  logic [31:0] lfsr = 32'h1D872B41;

  function automatic logic [31:0] step_rng(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    exp_t m_exp;
    bit   m_valid;
    bit   acc, hold, pend_ready;
    int   idx;
    string t, tr;

    rst_n = 1'b1; in_valid = 1'b0; out_ready = 1'b0; in_word = 32'd0;
    #1 rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R13", "out_valid in reset", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b0, "R13", "in_ready in reset", 64'(in_ready), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(in_ready == 1'b1, "R13", "in_ready after release", 64'(in_ready), 64'd1);
    chk(out_valid == 1'b0, "R13", "out_valid after release", 64'(out_valid), 64'd0);

    words = '{32'h0000_0000, 32'hFFFF_0000, 32'h0000_0004, 32'h0000_1FE0,
              32'h0000_5FFC, 32'h0000_7FFC, 32'h0000_DFFC, 32'h0000_FFFC,
              32'h0000_2000, 32'h0000_8000, 32'h0000_A000, 32'h0000_0001,
              32'hABCD_0001, 32'h0000_1FFD, 32'h0000_3FFD, 32'h0000_5FFD,
              32'h0000_6101, 32'h0000_717D, 32'h0000_6181, 32'h0000_7FFD,
              32'h0000_C001, 32'h0000_DFFD, 32'h0000_FFFD, 32'h0000_8001,
              32'h0000_A001, 32'h0000_1FFE, 32'h0000_3FFE, 32'h0000_7FFE,
              32'h0000_FFFE, 32'h0000_4002, 32'h0000_A002, 32'h0000_C002,
              32'h0000_8002, 32'h0000_8082, 32'h0000_8086, 32'h0000_9002,
              32'h0000_9082, 32'h0000_9086, 32'h0000_0013, 32'hFFFF_FFFF};
    for (int k = 0; k < 3000; k++) begin
      lfsr = step_rng(lfsr);
      words.push_back(lfsr);
    end

    m_valid = 0; idx = 0; pend_ready = 0;
    m_exp = model(32'd0);
    while (idx < words.size() || m_valid) begin
      @(negedge clk);
      lfsr = step_rng(lfsr);
      in_valid  = (idx < words.size()) && (lfsr[3:0] < 4'd11);
      in_word   = (idx < words.size()) ? words[idx] : 32'd0;
      out_ready = (lfsr[7:4] < 4'd12);
      #1;
      chk(in_ready == (!m_valid || out_ready), "R11", "in_ready",
          64'(in_ready), 64'(!m_valid || out_ready));
      acc  = in_valid && (!m_valid || out_ready);
      hold = m_valid && !out_ready;
      @(posedge clk);
      #1;
      if (acc) begin
        m_exp = model(in_word);
        m_valid = 1;
        idx++;
      end else if (out_ready) begin
        m_valid = 0;
      end
      chk(out_valid == m_valid, "R11", "out_valid", 64'(out_valid), 64'(m_valid));
      if (m_valid) begin
        t  = hold ? "R12" : tag_of(m_exp);
        tr = (!hold && (m_exp.op >= 1 && m_exp.op <= 5 || m_exp.op == 11 || m_exp.op == 12)) ? "R3" : t;
        chk(out_op == 5'(m_exp.op), t, "op", 64'(out_op), 64'(m_exp.op));
        chk(out_rd == 5'(m_exp.rd), tr, "rd", 64'(out_rd), 64'(m_exp.rd));
        chk(out_rs1 == 5'(m_exp.rs1), tr, "rs1", 64'(out_rs1), 64'(m_exp.rs1));
        chk(out_rs2 == 5'(m_exp.rs2), tr, "rs2", 64'(out_rs2), 64'(m_exp.rs2));
        chk(out_imm === m_exp.imm, t, "imm", out_imm, m_exp.imm);
        chk(out_len == 3'(m_exp.len), t, "len", 64'(out_len), 64'(m_exp.len));
        chk(out_illegal == 1'(m_exp.ill), t, "illegal", 64'(out_illegal), 64'(m_exp.ill));
      end
    end
    in_valid = 1'b0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule